// File: doc/BRIEF.md
# Audio Codec Control Register File

This block is the control register file of a primary audio codec. It holds up to 64 registers of 16 bits. A host writes a register with a byte address and a data word, and reads any register back through a separate read port. Every write goes through a filter that applies that register's rule before anything is stored.

The write rules are as follows:
- A write to the reset register loads every default value.
- A master volume write saturates an attenuation field when that field's overflow bit is set.
- The volume registers and the power-down register drop or keep certain bits.
- The identification registers cannot be written.
- The two sample-rate registers accept writes only in variable-rate mode. In that mode a written rate snaps to one of the supported rates.

Variable-rate mode is a two-state machine. The states are MODE_FIXED and MODE_VARIABLE. There are three transitions:
- T_ENABLE takes MODE_FIXED to MODE_VARIABLE on a write to the extended control register with bit 0 set.
- T_DISABLE takes MODE_VARIABLE back to MODE_FIXED on such a write with bit 0 clear.
- T_SOFT_RESET takes MODE_VARIABLE back to MODE_FIXED on a write to the reset register.

The block exports the master and PCM mute and attenuation fields and the current DAC rate. It also drives a one-cycle pulse each time the DAC rate changes, so that a downstream sample clock generator can react.

Top module: `codec_regfile_emu`

## Requirements
- R1: A write to address 0x00 stores no data. It loads every register with its default and returns the mode machine to MODE_FIXED. The defaults are:
  - 0x6A90 at 0x00.
  - 0x8000 at 0x02, 0x04, 0x06 and 0x1C.
  - 0x8008 at 0x0C and 0x0E.
  - 0x8808 at 0x10, 0x12, 0x14, 0x16 and 0x18.
  - 0x000F at 0x26, 0x0A05 at 0x28 and 0x0400 at 0x2A.
  - 48000 at 0x2C and 0x32.
  - 0x8384 at 0x7C and 0x7666 at 0x7E.
  - Zero at every other address.
- R2: A write to master volume (0x02) is filtered in two steps. First, data bit 13 set forces bits 12:8 to 0x1F, and data bit 5 set forces bits 4:0 to 0x1F. Then the result is ANDed with 0x9F1F and stored.
- R3: A write to PCM volume (0x18) stores the data ANDed with 0x9F1F, with no saturation step.
- R4: While bit 0 of the extended control register (0x2A) is 0, writes to 0x2C and 0x32 leave those registers unchanged.
- R5: While bit 0 of 0x2A is 1, a value V written to 0x2C or 0x32 is stored as follows:
  - V below 9512 stores 8000.
  - Below 13512 stores 11025.
  - Below 19025 stores 16000.
  - Below 27025 stores 22050.
  - Below 38050 stores 32000.
  - Below 46050 stores 44100.
  - Above 48000 stores 48000.
  - Otherwise V is stored unchanged.
- R6: A write to 0x2A changes only bit 0. A write with data bit 0 clear also sets both 0x2C and 0x32 to 48000.
- R7: A write to power-down (0x26) updates bits 15:8 from the data and keeps bits 7:0.
- R8: Writes to 0x28, 0x7C and 0x7E have no effect. A write to any address not named in R1 to R7 stores the data unchanged.
- R9: Address bit 0 is ignored on both ports, so the register index is address bits 6:1.
- R10: rate_chg is high for exactly the one cycle after the clock edge on which the DAC rate register value changed, and low otherwise.
- R11: The exported fields come from registers 0x02, 0x18 and 0x2C:
  - master_mute is bit 15 of 0x02, master_left is bits 12:8 and master_right is bits 4:0.
  - The pcm_* outputs take the same fields from 0x18.
  - dac_rate equals 0x2C.
- R12: Reading is combinational from rd_addr. An asynchronous low rst_n loads the R1 defaults and MODE_FIXED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 7 | Write byte address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 7 | Read byte address |
| rd_data | output | 16 | Read data |
| master_mute | output | 1 | Master mute bit |
| master_left | output | 5 | Master left attenuation |
| master_right | output | 5 | Master right attenuation |
| pcm_mute | output | 1 | PCM mute bit |
| pcm_left | output | 5 | PCM left attenuation |
| pcm_right | output | 5 | PCM right attenuation |
| dac_rate | output | 16 | Current DAC rate |
| rate_chg | output | 1 | One-cycle pulse on DAC rate change |

## Verification
A write presented before a rising edge takes effect at that edge. From then on, the register contents, the exported fields, dac_rate and rate_chg all show the new state. rd_data follows rd_addr with no clock at all.

The bench drives inputs on the falling edge and samples one falling edge after each write. At that point it compares the written register, the fields and the pulse with its own model. On the following falling edge, with no write in between, it checks that rate_chg has dropped again. Reads move rd_addr and sample a short delay later, within the same low phase.

// File: rtl/codec_rf_pkg.sv
package codec_rf_pkg;

    localparam int REG_W     = 16;
    localparam int VOL_W     = 5;
    localparam int NUM_RATES = 7;
    localparam int RATE_CEIL = 48000;

    // Register indices (byte address / 2); software decodes these positions.
    localparam int IX_RESET   = 0;
    localparam int IX_MASTER  = 1;
    localparam int IX_HPHONE  = 2;
    localparam int IX_MONO    = 3;
    localparam int IX_PHONE   = 6;
    localparam int IX_MIC     = 7;
    localparam int IX_LINE    = 8;
    localparam int IX_CD      = 9;
    localparam int IX_VIDEO   = 10;
    localparam int IX_AUX     = 11;
    localparam int IX_PCM     = 12;
    localparam int IX_RECGAIN = 14;
    localparam int IX_PWRDN   = 19;
    localparam int IX_EXTID   = 20;
    localparam int IX_EXTCTL  = 21;
    localparam int IX_DACRATE = 22;
    localparam int IX_ADCRATE = 25;
    localparam int IX_VEND1   = 62;
    localparam int IX_VEND2   = 63;

    localparam logic [REG_W-1:0] VOL_MASK = 16'h9F1F;

    typedef enum logic {
        MODE_FIXED    = 1'b0,
        MODE_VARIABLE = 1'b1
    } rate_mode_e;

    // Supported sample rates in ascending order.
    function automatic int rate_entry(input int i);
        case (i)
            0:       return 8000;
            1:       return 11025;
            2:       return 16000;
            3:       return 22050;
            4:       return 32000;
            5:       return 44100;
            default: return 48000;
        endcase
    endfunction

    function automatic logic [REG_W-1:0] default_val(input int idx);
        case (idx)
            IX_RESET:                                   return 16'h6A90;
            IX_MASTER, IX_HPHONE, IX_MONO, IX_RECGAIN:  return 16'h8000;
            IX_PHONE, IX_MIC:                           return 16'h8008;
            IX_LINE, IX_CD, IX_VIDEO, IX_AUX, IX_PCM:   return 16'h8808;
            IX_PWRDN:                                   return 16'h000F;
            IX_EXTID:                                   return 16'h0A05;
            IX_EXTCTL:                                  return 16'h0400;
            IX_DACRATE, IX_ADCRATE:                     return 16'(RATE_CEIL);
            IX_VEND1:                                   return 16'h8384;
            IX_VEND2:                                   return 16'h7666;
            default:                                    return '0;
        endcase
    endfunction

endpackage

// File: rtl/codec_rate_snap.sv
module codec_rate_snap
    import codec_rf_pkg::*;
(
    input  logic [REG_W-1:0] raw,
    output logic [REG_W-1:0] snapped
);
    localparam int N_MID = NUM_RATES - 1;

    logic [N_MID-1:0] below;

    for (genvar g = 0; g < N_MID; g++) begin : g_mid
        localparam int MID = rate_entry(g) + (rate_entry(g + 1) - rate_entry(g)) / 2;
        assign below[g] = (32'(raw) < 32'(MID));
    end

    // Lowest threshold that the value falls under wins; past the last
    // threshold the value passes through, clamped at the ceiling.
    always_comb begin
        snapped = (32'(raw) > 32'(RATE_CEIL)) ? REG_W'(RATE_CEIL) : raw;
        for (int i = N_MID - 1; i >= 0; i--) begin
            if (below[i]) snapped = REG_W'(rate_entry(i));
        end
    end
endmodule

// File: rtl/codec_write_filter.sv
module codec_write_filter
    import codec_rf_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [REG_W-1:0] data,
    input  logic [REG_W-1:0] old_val,
    input  logic             vra_on,
    output logic [REG_W-1:0] new_val,
    output logic             store,
    output logic             reset_all,
    output logic             force_rates
);
    logic [REG_W-1:0] snapped;
    logic [REG_W-1:0] sat;

    codec_rate_snap u_snap (
        .raw     (data),
        .snapped (snapped)
    );

    always_comb begin
        sat = data;
        if (data[13]) sat[12:8] = '1;
        if (data[5])  sat[4:0]  = '1;
    end

    always_comb begin
        new_val     = data;
        store       = 1'b1;
        reset_all   = 1'b0;
        force_rates = 1'b0;
        case (int'(idx))
            IX_RESET: begin
                store     = 1'b0;
                reset_all = 1'b1;
            end
            IX_MASTER:  new_val = sat & VOL_MASK;
            IX_PCM:     new_val = data & VOL_MASK;
            IX_EXTCTL: begin
                new_val     = {old_val[REG_W-1:1], data[0]};
                force_rates = ~data[0];
            end
            IX_DACRATE, IX_ADCRATE: begin
                store   = vra_on;
                new_val = snapped;
            end
            IX_PWRDN:   new_val = {data[REG_W-1:8], old_val[7:0]};
            IX_EXTID, IX_VEND1, IX_VEND2: store = 1'b0;
            default:    new_val = data;
        endcase
    end
endmodule

// File: rtl/codec_rate_mode_fsm.sv
module codec_rate_mode_fsm
    import codec_rf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic soft_reset,
    input  logic ctl_write,
    input  logic ctl_enable,
    output logic vra_on
);
    rate_mode_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_FIXED: begin
                if (ctl_write && ctl_enable) state_d = MODE_VARIABLE;     // T_ENABLE
            end
            MODE_VARIABLE: begin
                if (soft_reset)                    state_d = MODE_FIXED; // T_SOFT_RESET
                else if (ctl_write && !ctl_enable) state_d = MODE_FIXED; // T_DISABLE
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_FIXED;
        else        state_q <= state_d;
    end

    always_comb begin
        vra_on = (state_q == MODE_VARIABLE);
    end
endmodule

// File: rtl/codec_regfile_emu.sv
module codec_regfile_emu
    import codec_rf_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [REG_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [REG_W-1:0]    rd_data,
    output logic                master_mute,
    output logic [VOL_W-1:0]    master_left,
    output logic [VOL_W-1:0]    master_right,
    output logic                pcm_mute,
    output logic [VOL_W-1:0]    pcm_left,
    output logic [VOL_W-1:0]    pcm_right,
    output logic [REG_W-1:0]    dac_rate,
    output logic                rate_chg
);
    localparam int IDX_W = ADDR_W - 1;
    localparam int DEPTH = 1 << IDX_W;

    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;
    logic [REG_W-1:0] regs [DEPTH];
    logic [REG_W-1:0] old_val;
    logic [REG_W-1:0] new_val;
    logic             store, reset_all, force_rates;
    logic             vra_on;
    logic [REG_W-1:0] dac_next;
    logic             rate_chg_q;

    assign wr_idx  = wr_addr[ADDR_W-1:1];
    assign rd_idx  = rd_addr[ADDR_W-1:1];
    assign old_val = regs[wr_idx];

    codec_write_filter #(.IDX_W(IDX_W)) u_filter (
        .idx         (wr_idx),
        .data        (wr_data),
        .old_val     (old_val),
        .vra_on      (vra_on),
        .new_val     (new_val),
        .store       (store),
        .reset_all   (reset_all),
        .force_rates (force_rates)
    );

    codec_rate_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .soft_reset (wr_en && reset_all),
        .ctl_write  (wr_en && (int'(wr_idx) == IX_EXTCTL)),
        .ctl_enable (wr_data[0]),
        .vra_on     (vra_on)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_reg
        localparam logic [REG_W-1:0] DEF = default_val(g);
        logic [REG_W-1:0] q;
        logic             hit;

        assign hit    = wr_en && store && (wr_idx == IDX_W'(g));
        assign regs[g] = q;

        if ((g == IX_DACRATE) || (g == IX_ADCRATE)) begin : g_rate
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                  q <= DEF;
                else if (wr_en && reset_all) q <= DEF;
                else if (hit)                q <= new_val;
                else if (wr_en && force_rates) q <= REG_W'(RATE_CEIL);
            end
        end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                  q <= DEF;
                else if (wr_en && reset_all) q <= DEF;
                else if (hit)                q <= new_val;
            end
        end
    end

    // Next DAC rate, used only to form the change pulse.
    always_comb begin
        dac_next = regs[IX_DACRATE];
        if (wr_en) begin
            if (reset_all)                                       dac_next = REG_W'(RATE_CEIL);
            else if (store && (int'(wr_idx) == IX_DACRATE))      dac_next = new_val;
            else if (force_rates)                                dac_next = REG_W'(RATE_CEIL);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rate_chg_q <= 1'b0;
        else        rate_chg_q <= (dac_next != regs[IX_DACRATE]);
    end

    assign rd_data      = regs[rd_idx];
    assign master_mute  = regs[IX_MASTER][15];
    assign master_left  = regs[IX_MASTER][12:8];
    assign master_right = regs[IX_MASTER][4:0];
    assign pcm_mute     = regs[IX_PCM][15];
    assign pcm_left     = regs[IX_PCM][12:8];
    assign pcm_right    = regs[IX_PCM][4:0];
    assign dac_rate     = regs[IX_DACRATE];
    assign rate_chg     = rate_chg_q;
endmodule

// File: rtl/codec_rf_checker.sv
module codec_rf_checker
    import codec_rf_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [REG_W-1:0] wr_data,
    input logic             master_mute,
    input logic [VOL_W-1:0] master_left,
    input logic [REG_W-1:0] dac_rate,
    input logic             rate_chg,
    input logic             vra_on
);
    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assert_soft_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(wr_en && (int'(wr_idx) == IX_RESET)))
        |-> (dac_rate == 16'(RATE_CEIL) && master_mute && master_left == '0 && !vra_on));

    assert_master_sat_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(wr_en && (int'(wr_idx) == IX_MASTER) && wr_data[13]))
        |-> (master_left == 5'h1F));

    assert_fixed_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(wr_en && (int'(wr_idx) == IX_DACRATE) && !vra_on))
        |-> (dac_rate == $past(dac_rate)));

    assert_rate_ceiling_R5: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (dac_rate <= 16'(RATE_CEIL)));

    assert_rate_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (rate_chg == (dac_rate != $past(dac_rate))));
endmodule

bind codec_regfile_emu codec_rf_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .master_mute (master_mute),
    .master_left (master_left),
    .dac_rate    (dac_rate),
    .rate_chg    (rate_chg),
    .vra_on      (vra_on)
);

// File: tb/codec_regfile_emu_tb.sv
module codec_regfile_emu_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [6:0]  wr_addr;
    logic [15:0] wr_data;
    logic [6:0]  rd_addr;
    logic [15:0] rd_data;
    logic        master_mute, pcm_mute, rate_chg;
    logic [4:0]  master_left, master_right, pcm_left, pcm_right;
    logic [15:0] dac_rate;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    logic [15:0] mdl [64];

    always #(CLK_PERIOD / 2) clk = ~clk;

    codec_regfile_emu u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .master_mute(master_mute), .master_left(master_left), .master_right(master_right),
        .pcm_mute(pcm_mute), .pcm_left(pcm_left), .pcm_right(pcm_right),
        .dac_rate(dac_rate), .rate_chg(rate_chg)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            miscompares++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    function automatic logic [15:0] m_default(int i);
        case (i)
            0: return 16'h6A90;
            1, 2, 3, 14: return 16'h8000;
            6, 7: return 16'h8008;
            8, 9, 10, 11, 12: return 16'h8808;
            19: return 16'h000F;
            20: return 16'h0A05;
            21: return 16'h0400;
            22, 25: return 16'd48000;
            62: return 16'h8384;
            63: return 16'h7666;
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [15:0] m_snap(logic [15:0] v);
        if (v < 16'd9512)  return 16'd8000;
        if (v < 16'd13512) return 16'd11025;
        if (v < 16'd19025) return 16'd16000;
        if (v < 16'd27025) return 16'd22050;
        if (v < 16'd38050) return 16'd32000;
        if (v < 16'd46050) return 16'd44100;
        if (v > 16'd48000) return 16'd48000;
        return v;
    endfunction

    function automatic string tag_for(int i);
        case (i)
            0: return "R1";
            1: return "R2";
            12: return "R3";
            19: return "R7";
            21: return "R6";
            22, 25: return "R5";
            default: return "R8";
        endcase
    endfunction

    task automatic m_reset();
        for (int i = 0; i < 64; i++) mdl[i] = m_default(i);
    endtask

    task automatic m_write(int i, logic [15:0] d);
        logic [15:0] t;
        case (i)
            0: m_reset();
            1: begin
                t = d;
                if (d[13]) t = t | 16'h1F00;
                if (d[5])  t = t | 16'h001F;
                mdl[1] = t & 16'h9F1F;
            end
            12: mdl[12] = d & 16'h9F1F;
            21: begin
                mdl[21] = {mdl[21][15:1], d[0]};
                if (!d[0]) begin mdl[22] = 16'd48000; mdl[25] = 16'd48000; end
            end
            22, 25: if (mdl[21][0]) mdl[i] = m_snap(d);
            19: mdl[19] = {d[15:8], mdl[19][7:0]};
            20, 62, 63: ;
            default: mdl[i] = d;
        endcase
    endtask

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic read_chk(string tag, int i);
        rd_addr = 7'((i << 1) | ($urandom & 1)); // R9: low address bit ignored
        #1;
        chk(tag, rd_data, mdl[i]);
    endtask

    task automatic check_fields(string tag);
        chk({tag, "/R11 master"}, {master_mute, master_left, master_right},
            {mdl[1][15], mdl[1][12:8], mdl[1][4:0]});
        chk({tag, "/R11 pcm"}, {pcm_mute, pcm_left, pcm_right},
            {mdl[12][15], mdl[12][12:8], mdl[12][4:0]});
        chk({tag, "/R11 dac_rate"}, dac_rate, mdl[22]);
    endtask

    // Drive on a falling edge, take effect at the next rising edge,
    // sample at the falling edge after it; then confirm the pulse drops.
    task automatic wr(string tag, logic [6:0] a, logic [15:0] d);
        logic [15:0] old_dac;
        int i;
        i = int'(a[6:1]);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        old_dac = mdl[22];
        m_write(i, d);
        #1;
        chk({tag, "/R10 pulse"}, rate_chg, (mdl[22] != old_dac));
        check_fields(tag);
        read_chk(tag, i);
        read_chk({tag, " adc"}, 25);
        @(negedge clk);
        #1;
        chk({tag, "/R10 drop"}, rate_chg, 1'b0);
    endtask

    localparam int NSPEC = 20;
    function automatic int spec_idx(int k);
        case (k)
            0: return 0;   1: return 1;   2: return 2;   3: return 3;
            4: return 6;   5: return 8;   6: return 12;  7: return 14;
            8: return 19;  9: return 20;  10: return 21; 11: return 22;
            12: return 25; 13: return 62; 14: return 63; 15: return 22;
            16: return 21; 17: return 1;  18: return 12; default: return 22;
        endcase
    endfunction

    initial begin
        void'($urandom(32'h5EED_0C0D));
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R12: reset state of every register, fields and pulse
        for (int i = 0; i < 64; i++) read_chk("R12 reset", i);
        check_fields("R12 reset");
        chk("R12 pulse idle", rate_chg, 1'b0);

        // Directed corner cases
        wr("R4 fixed-mode ignore", 7'h2C, 16'd8000);
        wr("R4 adc ignore", 7'h32, 16'd16000);
        wr("R6 only bit0", 7'h2A, 16'hFFFF);
        wr("R5 below 9512", 7'h2C, 16'd9511);
        wr("R5/R9 odd address 9512", 7'h2D, 16'd9512);
        wr("R5 pass-through 47000", 7'h32, 16'd47000);
        wr("R5 clamp 50000", 7'h2C, 16'd50000);
        wr("R5 just below 46050", 7'h2C, 16'd46049);
        wr("R5 at 46050", 7'h2C, 16'd46050);
        wr("R6 disable forces 48000", 7'h2A, 16'h0000);
        wr("R2 saturate both", 7'h02, 16'h2020);
        wr("R2 mask only", 7'h02, 16'hFFDF);
        wr("R3 pcm mask", 7'h18, 16'hFFFF);
        wr("R7 power-down", 7'h26, 16'hABCD);
        wr("R8 ext id read-only", 7'h28, 16'h1234);
        wr("R8 vendor read-only", 7'h7E, 16'h0000);
        wr("R8 vendor1 read-only", 7'h7C, 16'hFFFF);
        wr("R8 plain store", 7'h40, 16'hBEEF);
        wr("R6 enable", 7'h2A, 16'h0001);
        wr("R5 snap 20000", 7'h2C, 16'd20000);
        wr("R1 soft reset", 7'h00, 16'h1234);
        for (int i = 0; i < 64; i++) read_chk("R1 defaults", i);
        wr("R1 mode fixed after reset", 7'h2C, 16'd8000);

        // Constrained random mix
        for (int n = 0; n < 600; n++) begin
            int i;
            logic [15:0] d;
            int k;
            k = int'($urandom_range(0, NSPEC + 3));
            if (k >= NSPEC) i = int'($urandom_range(1, 63));
            else            i = spec_idx(k);
            if (i == 0 && $urandom_range(0, 3) != 0) i = 22;
            if (i == 22 || i == 25) d = 16'($urandom_range(0, 60000));
            else                    d = 16'($urandom);
            wr(tag_for(i), 7'((i << 1) | ($urandom & 1)), d);
        end
        for (int i = 0; i < 64; i++) read_chk({"final ", tag_for(i)}, i);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule